// File: doc/BRIEF.md
# Programmable Symmetric Function Lattice

This combinational block evaluates totally symmetric Boolean functions of an N-bit input word. The value of such a function depends only on how many input bits are 1. No adder or population counter is used. A triangular lattice of two-input sort cells handles one new input per level. Each cell gives the AND (minimum) and the OR (maximum) of its two inputs. The last level yields every "at least k ones" threshold.

A row of XOR gates compares neighbouring thresholds and produces the "exactly k ones" vector. A row of OR gates then forms M independent function outputs from it. Each function output is configured by its own (N+1)-bit mask of accepted one-counts.

A type parameter places an optional register stage behind all three output groups. That register has a synchronous active-high reset.

Top module: `symlat_top`

## Requirements
- R1: `atleast_o[k-1]` is 1 exactly when at least k bits of `in_vec` are 1, for k = 1..N_IN.
- R2: `atleast_o[0]` equals the OR of all input bits, and `atleast_o[N_IN-1]` equals the AND of all input bits.
- R3: `exact_o[k]` is 1 exactly when k bits of `in_vec` are 1, for k = 0..N_IN, so exactly one bit of `exact_o` is set. `exact_o[0]` is 1 for the all-zero input.
- R4: Function m uses mask bits `fn_mask[m*(N_IN+1)+k]` for k = 0..N_IN. `fn_o[m]` equals the mask bit at k = the number of ones in `in_vec`.
- R5: A mask slice of all zeros forces its function output to 0 for every input. A slice of all ones forces it to 1.
- R6: The thresholds are monotone: `atleast_o[k]` set implies `atleast_o[k-1]` set.
- R7: With `OUT_MODE = OUT_REG`, all outputs show the result for the inputs present at the previous rising edge of `clk`. A high `rst` at a rising edge clears `atleast_o`, `exact_o` and `fn_o` to 0, whatever the inputs are.
- R8: With `OUT_MODE = OUT_COMB`, the outputs follow `in_vec` and `fn_mask` without any clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| in_vec | input | N_IN | Input bits of the symmetric functions |
| fn_mask | input | N_FN*(N_IN+1) | Per-function masks of accepted one-counts |
| atleast_o | output | N_IN | Threshold vector, bit k-1 = at least k ones |
| exact_o | output | N_IN+1 | Single-count vector, bit k = exactly k ones |
| fn_o | output | N_FN | Programmed symmetric function outputs |

## Verification
The bench builds two instances.

The first has N_IN = 5, N_FN = 3 and registered outputs. It is small enough to walk all 32 input words under several mask sets. This covers every count, both constant masks and all three function slots. It also exercises the one-edge latency and the reset clear.

The second has N_IN = 12, N_FN = 2 and combinational outputs. Random words and masks reach a deeper lattice, whose lower levels are never at full width with the smaller instance.

// File: rtl/symlat_pkg.sv
package symlat_pkg;

    typedef enum logic {
        OUT_COMB = 1'b0,
        OUT_REG  = 1'b1
    } out_mode_e;

    // Bit offset of function slot fn inside a packed mask bus for n inputs.
    function automatic int mask_base(input int fn, input int n);
        return fn * (n + 1);
    endfunction

endpackage

// File: rtl/symlat_minmax.sv
module symlat_minmax (
    input  logic a,
    input  logic b,
    output logic lo,
    output logic hi
);
    assign lo = a & b;
    assign hi = a | b;
endmodule

// File: rtl/symlat_level.sv
module symlat_level #(
    parameter int N   = 8,
    parameter int LVL = 1
) (
    input  logic         x,
    input  logic [N:0]   prev,
    output logic [N:0]   next
);
    // Carry runs down the sorted column: c[j] = x AND prev[j-1].
    logic [LVL:1] c;

    assign c[1]    = x;
    assign next[0] = 1'b1;

    genvar j;
    generate
        for (j = 1; j < LVL; j++) begin : g_cell
            symlat_minmax u_cell (
                .a  (prev[j]),
                .b  (c[j]),
                .lo (c[j+1]),
                .hi (next[j])
            );
        end
        assign next[LVL] = c[LVL];
        for (j = LVL + 1; j <= N; j++) begin : g_idle
            assign next[j] = 1'b0;
        end
    endgenerate

    // The previous level may only hold thresholds it can have reached.
    always_comb begin
        assert_prev_clean_R6: assert (prev[0] == 1'b1 && prev[N:LVL] == '0);
    end

endmodule

// File: rtl/symlat_lattice.sv
module symlat_lattice #(
    parameter int N = 8
) (
    input  logic [N-1:0] x,
    output logic [N:0]   thr
);
    logic [N:0] lv [0:N];

    assign lv[0] = {{N{1'b0}}, 1'b1};

    genvar i;
    generate
        for (i = 1; i <= N; i++) begin : g_lvl
            symlat_level #(.N(N), .LVL(i)) u_lvl (
                .x    (x[i-1]),
                .prev (lv[i-1]),
                .next (lv[i])
            );
        end
    endgenerate

    assign thr = lv[N];

endmodule

// File: rtl/symlat_decode.sv
module symlat_decode #(
    parameter int N = 8
) (
    input  logic [N:0] thr,
    output logic [N:0] exact
);
    // Bit 0 of thr is the constant "at least 0"; bit N+1 is a constant 0.
    logic [N+1:0] ext;
    assign ext = {1'b0, thr};

    genvar k;
    generate
        for (k = 0; k <= N; k++) begin : g_xor
            assign exact[k] = ext[k] ^ ext[k+1];
        end
    endgenerate

    always_comb begin
        assert_onehot_R3: assert ($onehot(exact));
    end

endmodule

// File: rtl/symlat_select.sv
module symlat_select #(
    parameter int N = 8,
    parameter int M = 2
) (
    input  logic [M*(N+1)-1:0] mask,
    input  logic [N:0]         exact,
    output logic [M-1:0]       fn
);
    genvar m;
    generate
        for (m = 0; m < M; m++) begin : g_fn
            localparam int BASE = symlat_pkg::mask_base(m, N);
            assign fn[m] = |(mask[BASE +: N+1] & exact);
        end
    endgenerate
endmodule

// File: rtl/symlat_top.sv
module symlat_top #(
    parameter int                    N_IN     = 8,
    parameter int                    N_FN     = 2,
    parameter symlat_pkg::out_mode_e OUT_MODE = symlat_pkg::OUT_COMB
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [N_IN-1:0]           in_vec,
    input  logic [N_FN*(N_IN+1)-1:0]  fn_mask,
    output logic [N_IN-1:0]           atleast_o,
    output logic [N_IN:0]             exact_o,
    output logic [N_FN-1:0]           fn_o
);
    import symlat_pkg::*;

    localparam int MASK_W = N_FN * (N_IN + 1);

    logic [N_IN:0]   thr_w;
    logic [N_IN:0]   exact_w;
    logic [N_FN-1:0] fn_w;

    symlat_lattice #(.N(N_IN)) u_lattice (
        .x   (in_vec),
        .thr (thr_w)
    );

    symlat_decode #(.N(N_IN)) u_decode (
        .thr   (thr_w),
        .exact (exact_w)
    );

    symlat_select #(.N(N_IN), .M(N_FN)) u_select (
        .mask  (fn_mask),
        .exact (exact_w),
        .fn    (fn_w)
    );

    generate
        if (OUT_MODE == OUT_REG) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) begin
                    atleast_o <= '0;
                    exact_o   <= '0;
                    fn_o      <= '0;
                end else begin
                    atleast_o <= thr_w[N_IN:1];
                    exact_o   <= exact_w;
                    fn_o      <= fn_w;
                end
            end

            assert_reg_follow_R7: assert property (@(posedge clk) disable iff (rst)
                1'b1 |=> (fn_o == $past(fn_w) && exact_o == $past(exact_w)));
        end else begin : g_comb
            assign atleast_o = thr_w[N_IN:1];
            assign exact_o   = exact_w;
            assign fn_o      = fn_w;
        end
    endgenerate

    assert_or_and_R2: assert property (@(posedge clk) disable iff (rst)
        (thr_w[1] == (|in_vec)) && (thr_w[N_IN] == (&in_vec)));

    assert_mono_R6: assert property (@(posedge clk) disable iff (rst)
        ((thr_w[N_IN:2] & ~thr_w[N_IN-1:1]) == '0));

    assert_count_R1: assert property (@(posedge clk) disable iff (rst)
        $countones(thr_w[N_IN:1]) == $countones(in_vec));

    genvar m;
    generate
        for (m = 0; m < N_FN; m++) begin : g_fn_chk
            localparam int BASE = mask_base(m, N_IN);
            assert_fn_R4: assert property (@(posedge clk) disable iff (rst)
                fn_w[m] == fn_mask[MASK_W'(BASE) + MASK_W'($countones(in_vec))]);
        end
    endgenerate

endmodule

// File: tb/test_symlat_top.sv
module test_symlat_top;
    import symlat_pkg::*;

    localparam int NA = 5;
    localparam int MA = 3;
    localparam int NB = 12;
    localparam int MB = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic [NA-1:0]        a_in;
    logic [MA*(NA+1)-1:0] a_mask;
    logic [NA-1:0]        a_thr;
    logic [NA:0]          a_ex;
    logic [MA-1:0]        a_fn;

    logic [NB-1:0]        b_in;
    logic [MB*(NB+1)-1:0] b_mask;
    logic [NB-1:0]        b_thr;
    logic [NB:0]          b_ex;
    logic [MB-1:0]        b_fn;

    symlat_top #(.N_IN(NA), .N_FN(MA), .OUT_MODE(OUT_REG)) i_symlat_top (
        .clk(clk), .rst(rst), .in_vec(a_in), .fn_mask(a_mask),
        .atleast_o(a_thr), .exact_o(a_ex), .fn_o(a_fn)
    );

    symlat_top #(.N_IN(NB), .N_FN(MB), .OUT_MODE(OUT_COMB)) i_symlat_top_wide (
        .clk(clk), .rst(rst), .in_vec(b_in), .fn_mask(b_mask),
        .atleast_o(b_thr), .exact_o(b_ex), .fn_o(b_fn)
    );

    int n_chk  = 0;
    int n_fail = 0;

    // Masks for the table: fn0 = at least 3 ones, fn1 = odd count, fn2 = count 0 or 5.
    localparam logic [MA*(NA+1)-1:0] TBL_MASK = {6'b100001, 6'b101010, 6'b111000};
    // Each row: {in_vec[4:0], expected fn_o[2:0]}
    localparam logic [7:0] VEC [8] = '{
        {5'b00000, 3'b100},
        {5'b11111, 3'b111},
        {5'b00001, 3'b010},
        {5'b00111, 3'b011},
        {5'b01010, 3'b000},
        {5'b11110, 3'b001},
        {5'b10101, 3'b011},
        {5'b11000, 3'b000}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_thr(input int cnt);
        return (32'd1 << cnt) - 32'd1;
    endfunction

    function automatic logic [31:0] ref_fn(input logic [63:0] mask, input int cnt,
                                           input int n, input int m);
        logic [31:0] r = '0;
        for (int j = 0; j < m; j++) r[j] = mask[j*(n+1)+cnt];
        return r;
    endfunction

    task automatic sweep_a(input logic [MA*(NA+1)-1:0] mask);
        a_mask = mask;
        for (int v = 0; v < (1 << NA); v++) begin
            a_in = NA'(v);
            @(negedge clk);
            check("R1 R6 thresholds", 32'(a_thr), ref_thr($countones(NA'(v))));
            check("R2 or/and ends", {30'd0, a_thr[NA-1], a_thr[0]},
                  {30'd0, &NA'(v), |NA'(v)});
            check("R3 exact count", 32'(a_ex), 32'd1 << $countones(NA'(v)));
            check("R4 R5 function", 32'(a_fn),
                  ref_fn(64'(mask), $countones(NA'(v)), NA, MA));
        end
    endtask

    initial begin
        #(20 * 100000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        a_in   = '0;
        a_mask = '1;
        b_in   = '0;
        b_mask = '0;
        rst    = 1'b1;
        @(negedge clk);
        a_in = '1;
        @(negedge clk);
        // R7: reset clears the register although the inputs would drive ones
        check("R7 reset atleast", 32'(a_thr), 32'd0);
        check("R7 reset exact", 32'(a_ex), 32'd0);
        check("R7 reset fn", 32'(a_fn), 32'd0);

        rst    = 1'b0;
        a_mask = TBL_MASK;
        for (int i = 0; i < 8; i++) begin
            a_in = VEC[i][7:3];
            @(negedge clk);
            check("R4 table fn", 32'(a_fn), 32'(VEC[i][2:0]));
        end

        // R7: new inputs are not visible before the next rising edge
        a_in = 5'b11111;
        #1;
        check("R7 hold before edge", 32'(a_fn), 32'd0);
        check("R7 hold exact", 32'(a_ex), 32'h04);
        @(negedge clk);
        check("R7 after edge", 32'(a_fn), 32'b111);

        sweep_a(TBL_MASK);
        // R5: fn0 constant 1, fn1 constant 0, fn2 even counts
        sweep_a({6'b010101, 6'b000000, 6'b111111});
        sweep_a({6'b000000, 6'b111111, 6'b000001});

        // R8: wide combinational instance, no clock between drive and sample
        for (int i = 0; i < 300; i++) begin
            b_in   = NB'($urandom);
            b_mask = (i < 4) ? ((i % 2 == 0) ? '0 : '1) : (MB*(NB+1))'($urandom);
            #1;
            check("R8 R1 wide thresholds", 32'(b_thr), ref_thr($countones(b_in)));
            check("R8 R3 wide exact", 32'(b_ex), 32'd1 << $countones(b_in));
            check("R8 R4 wide fn", 32'(b_fn),
                  ref_fn(64'(b_mask), $countones(b_in), NB, MB));
        end
        b_in = '1;
        #1;
        check("R8 R2 wide all ones", {30'd0, b_thr[NB-1], b_ex[NB]}, 32'b11);
        b_in = '0;
        #1;
        check("R8 R2 wide all zero", {30'd0, b_thr[0], b_ex[0]}, 32'b01);

        @(negedge clk);
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule